// File: doc/BRIEF.md
# Time-Triggered Compare Match Unit

This block holds the compare and interrupt logic of a time-triggered CAN controller. Three compare channels each keep a 16-bit compare value that software can write. Channel 0 watches the free-running local time counter. Channels 1 and 2 watch the cycle time counter. When a channel's counter first reaches its compare value, the block raises a sticky interrupt-request flag and a status flag for that channel, provided the channel's enable bit is set. Channel 0 can also emit a one-cycle pulse that resets the local timer. Channel 2 always emits a one-cycle pulse that flushes the pending transmit queue.

A reference-mark register records the local time at the start of frame of a reference message. The captured value is held as pending until the frame outcome is known, and it is committed only when the frame completes successfully. In event-triggered mode the register reads zero. Both counters, the frame outcome strobes and the mode come from the surrounding controller.

Top module: `ttcm_unit`

## Requirements
- R1: Each of the three compare registers is written only when its own bit of `cmp_we` is set (bit n selects channel n). `cmp_rdata` returns the value of the register chosen by `cmp_rsel` (0, 1 or 2), and returns zero for selector 3.
- R2: Channel 0 compares against `local_time`. Channels 1 and 2 compare against `cycle_time`. A value on the other counter never produces a match.
- R3: A match is taken only on a clock edge where the counter equals the compare value and did not equal it on the previous edge. A counter that holds an equal value does not produce a second match. Every effect of a match is visible in the cycle after the edge that sampled it.
- R4: Matches on channels 0, 1 and 2 set their request flags only while `ctrl` bits 12, 11 and 10 respectively are 1. With the bit at 0, the match sets no flag.
- R5: A flagged match sets `irr` bit 11, 15 or 14 and `status` bit 3, 2 or 1 for channels 0, 1 and 2. All other bits of `irr` and `status` read 0, and the flags are sticky.
- R6: Writing 1 to an `irr_clr` bit at position 11, 15 or 14 clears that request bit and its status bit in the next cycle. A set in the same cycle takes priority over the clear.
- R7: `irq` is the OR over the three channels of the request bit AND NOT the `irq_mask` bit at the same position (11, 15, 14). The mask blocks `irq` only and leaves the flags unchanged.
- R8: `timer_clr` is a one-cycle pulse after a channel 0 match while `ctrl` bit 6 is 1, whether or not the flag enable is set. While bit 6 is 0, no pulse is produced.
- R9: `queue_flush` is a one-cycle pulse after every channel 2 match.
- R10: In time-trigger mode (`tt_mode`=1), `sof` with `sof_ref`=1 captures `local_time` as pending. A later `frame_ok` commits the pending value to `ref_mark`. `frame_fail` discards it. A start of frame with `sof_ref`=0 is ignored.
- R11: While `tt_mode` is 0, `ref_mark` reads 0 from the next cycle on, and no capture is taken.
- R12: After reset, `irr`, `status`, `irq`, `timer_clr`, `queue_flush`, `ref_mark` and all compare registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_time | input | 16 | Local time counter value |
| cycle_time | input | 16 | Cycle time counter value |
| tt_mode | input | 1 | 1 = time-trigger mode, 0 = event-triggered mode |
| ctrl | input | 16 | Control word: bits 12/11/10 flag enables, bit 6 timer-clear enable |
| irq_mask | input | 16 | Interrupt mask, bits 11/15/14 |
| irr_clr | input | 16 | Write-1-to-clear strobe for the request bits |
| cmp_we | input | 3 | Per-channel compare write enable |
| cmp_wdata | input | 16 | Compare write data |
| cmp_rsel | input | 2 | Compare readback select |
| cmp_rdata | output | 16 | Selected compare value |
| sof | input | 1 | Start-of-frame strobe |
| sof_ref | input | 1 | The frame starting is a reference message |
| frame_ok | input | 1 | Frame completed successfully |
| frame_fail | input | 1 | Frame failed |
| irr | output | 16 | Interrupt request flags |
| status | output | 4 | Timer status flags, bits 3/2/1 |
| irq | output | 1 | Combined interrupt output |
| timer_clr | output | 1 | Local timer reset pulse |
| queue_flush | output | 1 | Transmit queue flush pulse |
| ref_mark | output | 16 | Reference mark |

## Verification
The assertions check on every cycle that the timer-clear and flush pulses never last two cycles and that a timer-clear pulse only follows a cycle with control bit 6 set. They also check that a request flag rises only with its enable set and falls only after a clear strobe, and that the reference mark changes only after a success strobe and stays zero in event-triggered mode. The bench scenarios cover what the assertions cannot see on their own. These are the choice of time base for each channel, the absence of a retrigger while a counter holds, the interplay of mask and flag, and the discard of a pending capture on a failed or non-reference frame.

// File: rtl/ttcm_pkg.sv
// Package: shared bit positions of the compare match unit.
// Assumes three channels; the position helpers map a channel index to its
// request, status and enable bit.
package ttcm_pkg;
    localparam int NCH       = 3;
    localparam int TW        = 16;
    localparam int TCLR_BIT  = 6;

    // Request bit per channel.
    function automatic int irr_pos(int ch);
        case (ch)
            0:       return 11;
            1:       return 15;
            default: return 14;
        endcase
    endfunction

    // Status bit per channel.
    function automatic int sts_pos(int ch);
        return 3 - ch;
    endfunction

    // Flag-enable bit per channel.
    function automatic int en_pos(int ch);
        return 12 - ch;
    endfunction
endpackage

// File: rtl/ttcm_chan.sv
// Module: one compare channel. Holds a writable compare value and reports
// a single-cycle hit when the watched counter first equals it.
// Assumes the counter is stable around the clock edge.
module ttcm_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cmp_q,
    output logic         hit
);
    logic eq;
    logic eq_q;

    // Equality of counter and compare value, and its rising edge.
    always_comb begin
        eq  = (cnt == cmp_q);
        hit = eq & ~eq_q;
    end

    // Compare register and previous-equality state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            eq_q  <= 1'b0;
        end else begin
            if (we) cmp_q <= wdata;
            eq_q <= eq;
        end
    end
endmodule

// File: rtl/ttcm_flags.sv
// Module: sticky request flags, one per channel, set by an enabled hit and
// cleared by a write-1-to-clear strobe; set wins over clear.
module ttcm_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req
);
    // Flag update per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= '0;
        else        req <= (hit & en) | (req & ~clr);
    end
endmodule

// File: rtl/ttcm_refmark.sv
// Module: reference-mark capture. A start of frame of a reference message
// records the local time as pending; success commits it, failure drops it.
// In event-triggered mode the mark and the pending capture are cleared.
module ttcm_refmark #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tt_mode,
    input  logic         sof,
    input  logic         sof_ref,
    input  logic         frame_ok,
    input  logic         frame_fail,
    input  logic [W-1:0] ltime,
    output logic [W-1:0] mark
);
    logic [W-1:0] pend;
    logic         pend_v;

    // Pending capture, commit on success, clear outside time-trigger mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !tt_mode) begin
            mark   <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else begin
            if (frame_ok && pend_v) mark <= pend;
            if (frame_ok || frame_fail) pend_v <= 1'b0;
            if (sof && sof_ref) begin
                pend   <= ltime;
                pend_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ttcm_unit.sv
// Module: top of the compare match unit. Instantiates three channels
// (channel 0 on local time, the others on cycle time), the request flags,
// and the reference-mark capture; drives the side-action pulses.
// Assumes both counters and all strobes are synchronous to clk.
module ttcm_unit
    import ttcm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] local_time,
    input  logic [TW-1:0] cycle_time,
    input  logic          tt_mode,
    input  logic [15:0]   ctrl,
    input  logic [15:0]   irq_mask,
    input  logic [15:0]   irr_clr,
    input  logic [NCH-1:0] cmp_we,
    input  logic [TW-1:0] cmp_wdata,
    input  logic [1:0]    cmp_rsel,
    output logic [TW-1:0] cmp_rdata,
    input  logic          sof,
    input  logic          sof_ref,
    input  logic          frame_ok,
    input  logic          frame_fail,
    output logic [15:0]   irr,
    output logic [3:0]    status,
    output logic          irq,
    output logic          timer_clr,
    output logic          queue_flush,
    output logic [TW-1:0] ref_mark
);
    logic [TW-1:0]  cmp_v [NCH];
    logic [NCH-1:0] hit;
    logic [NCH-1:0] en;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] req;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            ttcm_chan #(.W(TW)) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (cmp_we[g]),
                .wdata (cmp_wdata),
                .cnt   ((g == 0) ? local_time : cycle_time),
                .cmp_q (cmp_v[g]),
                .hit   (hit[g])
            );
            assign en[g]  = ctrl[en_pos(g)];
            assign clr[g] = irr_clr[irr_pos(g)];
        end
    endgenerate

    ttcm_flags #(.N(NCH)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .en    (en),
        .clr   (clr),
        .req   (req)
    );

    ttcm_refmark #(.W(TW)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .tt_mode    (tt_mode),
        .sof        (sof),
        .sof_ref    (sof_ref),
        .frame_ok   (frame_ok),
        .frame_fail (frame_fail),
        .ltime      (local_time),
        .mark       (ref_mark)
    );

    // Map channel flags to request/status words and combine the interrupt.
    always_comb begin
        irr    = '0;
        status = '0;
        irq    = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            irr[irr_pos(c)]    = req[c];
            status[sts_pos(c)] = req[c];
            irq = irq | (req[c] & ~irq_mask[irr_pos(c)]);
        end
    end

    // Compare readback selection.
    always_comb begin
        case (cmp_rsel)
            2'd0:    cmp_rdata = cmp_v[0];
            2'd1:    cmp_rdata = cmp_v[1];
            2'd2:    cmp_rdata = cmp_v[2];
            default: cmp_rdata = '0;
        endcase
    end

    // Side-action pulses: timer reset on channel 0, queue flush on channel 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_clr   <= 1'b0;
            queue_flush <= 1'b0;
        end else begin
            timer_clr   <= hit[0] & ctrl[TCLR_BIT];
            queue_flush <= hit[NCH-1];
        end
    end
endmodule

// File: rtl/ttcm_unit_chk.sv
// Module: property checker for ttcm_unit, attached by bind below.
module ttcm_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tt_mode,
    input logic [15:0] ctrl,
    input logic [15:0] irr_clr,
    input logic        frame_ok,
    input logic [15:0] irr,
    input logic        timer_clr,
    input logic        queue_flush,
    input logic [15:0] ref_mark
);
    a_r8_tclr_single: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clr |=> !timer_clr);
    a_r9_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        queue_flush |=> !queue_flush);
    a_r8_tclr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_clr) |-> $past(ctrl[6]));
    a_r4_ch0_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irr[11]) |-> $past(ctrl[12]));
    a_r4_ch1_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irr[15]) |-> $past(ctrl[11]));
    a_r4_ch2_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irr[14]) |-> $past(ctrl[10]));
    a_r6_ch0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irr[11]) |-> $past(irr_clr[11]));
    a_r10_commit_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tt_mode) && !$stable(ref_mark)) |-> $past(frame_ok));
    a_r11_et_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tt_mode) |-> (ref_mark == 16'h0));
endmodule

bind ttcm_unit ttcm_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tt_mode     (tt_mode),
    .ctrl        (ctrl),
    .irr_clr     (irr_clr),
    .frame_ok    (frame_ok),
    .irr         (irr),
    .timer_clr   (timer_clr),
    .queue_flush (queue_flush),
    .ref_mark    (ref_mark)
);

// File: tb/sim_ttcm_unit.sv
module sim_ttcm_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] local_time, cycle_time;
    logic        tt_mode;
    logic [15:0] ctrl, irq_mask, irr_clr;
    logic [2:0]  cmp_we;
    logic [15:0] cmp_wdata;
    logic [1:0]  cmp_rsel;
    logic [15:0] cmp_rdata;
    logic        sof, sof_ref, frame_ok, frame_fail;
    logic [15:0] irr;
    logic [3:0]  status;
    logic        irq, timer_clr, queue_flush;
    logic [15:0] ref_mark;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ttcm_unit u0 (
        .clk(clk), .rst_n(rst_n), .local_time(local_time), .cycle_time(cycle_time),
        .tt_mode(tt_mode), .ctrl(ctrl), .irq_mask(irq_mask), .irr_clr(irr_clr),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_rsel(cmp_rsel), .cmp_rdata(cmp_rdata),
        .sof(sof), .sof_ref(sof_ref), .frame_ok(frame_ok), .frame_fail(frame_fail),
        .irr(irr), .status(status), .irq(irq), .timer_clr(timer_clr),
        .queue_flush(queue_flush), .ref_mark(ref_mark)
    );

    typedef struct packed {
        logic [15:0] lt;
        logic [15:0] ct;
        logic [2:0]  req;   // {ch0, ch1, ch2} request bits
        logic        tclr;
        logic        flush;
        logic        irqx;
    } vec_t;

    // Compare values 0x10 / 0x20 / 0x30, all enables, timer-clear on, no mask.
    localparam vec_t VECS [6] = '{
        '{16'h0005, 16'h0005, 3'b000, 1'b0, 1'b0, 1'b0},
        '{16'h0010, 16'h0005, 3'b100, 1'b1, 1'b0, 1'b1},
        '{16'h0010, 16'h0005, 3'b100, 1'b0, 1'b0, 1'b1},
        '{16'h0011, 16'h0020, 3'b110, 1'b0, 1'b0, 1'b1},
        '{16'h0012, 16'h0030, 3'b111, 1'b0, 1'b1, 1'b1},
        '{16'h0012, 16'h0030, 3'b111, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, step one rising edge, sample 1 ns later.
    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic setc(input logic [15:0] lt, input logic [15:0] ct);
        @(negedge clk);
        local_time = lt;
        cycle_time = ct;
        step();
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; local_time = 16'h1; cycle_time = 16'h1; tt_mode = 1;
        ctrl = 0; irq_mask = 0; irr_clr = 0; cmp_we = 0; cmp_wdata = 0; cmp_rsel = 0;
        sof = 0; sof_ref = 0; frame_ok = 0; frame_fail = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R12 reset state
        chk("R12 irr", irr, 0);
        chk("R12 status", status, 0);
        chk("R12 irq", irq, 0);
        chk("R12 timer_clr", timer_clr, 0);
        chk("R12 queue_flush", queue_flush, 0);
        chk("R12 ref_mark", ref_mark, 0);
        chk("R12 cmp0", cmp_rdata, 0);

        // R1 independent compare writes and readback
        @(negedge clk); cmp_we = 3'b001; cmp_wdata = 16'h0010; step();
        @(negedge clk); cmp_we = 3'b010; cmp_wdata = 16'h0020; step();
        @(negedge clk); cmp_we = 3'b100; cmp_wdata = 16'h0030; step();
        @(negedge clk); cmp_we = 3'b000; cmp_wdata = 16'hFFFF; step();
        for (int s = 0; s < 4; s++) begin
            cmp_rsel = 2'(s);
            #1;
            chk("R1 readback", cmp_rdata, (s == 3) ? 0 : 16'h10 * (s + 1));
        end
        @(negedge clk); ctrl = 16'h1C40; step();

        // R3 R5 R8 R9 R7 vector walk
        for (int i = 0; i < 6; i++) begin
            setc(VECS[i].lt, VECS[i].ct);
            chk("R5 R3 req", {irr[11], irr[15], irr[14]}, VECS[i].req);
            chk("R5 status", status, {VECS[i].req, 1'b0});
            chk("R8 tclr", timer_clr, VECS[i].tclr);
            chk("R9 flush", queue_flush, VECS[i].flush);
            chk("R7 irq", irq, VECS[i].irqx);
        end
        chk("R5 unused zero", irr & 16'h37FF, 0);

        // R6 clear everything
        @(negedge clk); irr_clr = 16'hFFFF; local_time = 16'h100; cycle_time = 16'h100; step();
        @(negedge clk); irr_clr = 0; #1;
        chk("R6 irr cleared", irr, 0);
        chk("R6 status cleared", status, 0);

        // R2 channel 1 ignores local time, follows cycle time
        setc(16'h0020, 16'h0100);
        chk("R2 ch1 ignores local", irr, 0);
        setc(16'h0100, 16'h0020);
        chk("R2 ch1 on cycle", irr, 16'h8000);
        chk("R5 ch1 status", status, 4'b0100);
        setc(16'h0010, 16'h0100);
        chk("R2 ch0 on local", irr, 16'h8800);

        // R6 selective clear of bit 15
        @(negedge clk); irr_clr = 16'h8000; step();
        @(negedge clk); irr_clr = 16'h0800; #1;
        chk("R6 clear bit15", irr, 16'h0800);
        step();
        @(negedge clk); irr_clr = 0; #1;
        chk("R6 clear bit11", irr, 0);
        chk("R6 status zero", status, 0);

        // R4 flag disabled, R8 pulse still produced
        @(negedge clk); ctrl = 16'h0C40; local_time = 16'h100; step();
        setc(16'h0010, 16'h0100);
        chk("R4 no flag when disabled", irr[11], 0);
        chk("R8 tclr independent of enable", timer_clr, 1);
        step();
        chk("R8 tclr one cycle", timer_clr, 0);

        // R8 timer-clear suppressed with bit 6 low
        @(negedge clk); ctrl = 16'h1C00; local_time = 16'h100; step();
        setc(16'h0010, 16'h0100);
        chk("R8 no tclr bit6 low", timer_clr, 0);
        chk("R4 flag when enabled", irr[11], 1);

        // R7 mask blocks irq, not flag
        @(negedge clk); irq_mask = 16'h0800; #1;
        chk("R7 masked irq", irq, 0);
        chk("R7 flag kept", irr[11], 1);
        @(negedge clk); irq_mask = 16'h0000; #1;
        chk("R7 unmasked irq", irq, 1);

        // R9 flush pulse on ch2
        setc(16'h0100, 16'h0030);
        chk("R9 flush", queue_flush, 1);
        chk("R5 ch2 req", irr[14], 1);
        step();
        chk("R9 flush one cycle", queue_flush, 0);

        // R10 reference mark capture
        @(negedge clk); local_time = 16'h1234; sof = 1; sof_ref = 1; step();
        @(negedge clk); sof = 0; sof_ref = 0; #1;
        chk("R10 not before ok", ref_mark, 0);
        @(negedge clk); frame_ok = 1; step();
        @(negedge clk); frame_ok = 0; #1;
        chk("R10 commit on ok", ref_mark, 16'h1234);
        @(negedge clk); local_time = 16'h2222; sof = 1; sof_ref = 1; step();
        @(negedge clk); sof = 0; sof_ref = 0; frame_fail = 1; step();
        @(negedge clk); frame_fail = 0; frame_ok = 1; step();
        @(negedge clk); frame_ok = 0; #1;
        chk("R10 fail discards", ref_mark, 16'h1234);
        @(negedge clk); local_time = 16'h3333; sof = 1; sof_ref = 0; step();
        @(negedge clk); sof = 0; frame_ok = 1; step();
        @(negedge clk); frame_ok = 0; #1;
        chk("R10 non-reference ignored", ref_mark, 16'h1234);

        // R11 event-triggered mode reads zero
        @(negedge clk); tt_mode = 0; step();
        chk("R11 et zero", ref_mark, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule